// File: doc/BRIEF.md
# Halving Tree Sum Reducer

This block collapses a set of partial sums, stored in its own entry file, into one total. A host writes each partial sum through a load port while the block is idle, then pulses a start input. The block runs a sequence of rounds. Each round halves the number of live entries: the lower half of the live range adds the upper half into itself. When the live count is odd, the last live entry is first added into entry 0. Rounds continue until one live entry remains, and entry 0 then holds the total, which is copied to the result output together with a one-cycle done pulse.

A round is a barrier. Its fold cycle and all of its pair steps finish before the next round reads any entry. The pair additions of a round are shared out over a parameterised number of adder lanes, so each round takes one fold cycle and ceil(half / LANES) pair cycles. Lane 0 also performs the odd fold. All arithmetic wraps modulo 2^DATA_W, and there is no overflow indication.

Top module: `halving_sum_reducer`

## Requirements
- R1: While idle, a cycle with `load_en` high writes `load_data` to entry `load_idx`. A load whose index is N_ENTRIES or larger changes no entry.
- R2: Loads presented while `busy` is high are ignored and do not disturb the running reduction.
- R3: A `start` pulse while `busy` is high is ignored. The run in progress keeps its latency and its result.
- R4: `result` equals the sum of all N_ENTRIES loaded entries, including for counts that are not powers of two. An odd live count folds entry count−1 into entry 0 before that round's halving.
- R5: Every addition wraps modulo 2^DATA_W.
- R6: `done` is high for exactly one cycle per run, and `busy` is low in that cycle.
- R7: `result` is updated only in the cycle `done` rises and holds its value until the next completed run, whatever loads occur meanwhile.
- R8: With N_ENTRIES = 1, `done` rises on the second clock edge after start is sampled, and `result` equals entry 0. No addition is made.
- R9: After reset `busy` and `done` are low and `result` is 0. `busy` goes high on the edge that samples `start` and stays high until `done`.
- R10: Counting from the edge that samples `start`, `done` rises after 2 + Σ over rounds of (1 + ceil(h / LANES)) edges, where h = floor(c / 2) for each live count c > 1.
- R11: At the end of every round the live count becomes floor of its previous value divided by two, and the run finishes only when it equals 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Write strobe for one entry |
| load_idx | input | IDX_W | Entry index for the write |
| load_data | input | DATA_W | Partial sum to write |
| start | input | 1 | One-cycle request to begin a reduction |
| busy | output | 1 | High while a reduction runs |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W | Total of the last completed run |

## Verification
The embedded properties watch every cycle: done is a single-cycle pulse that never overlaps busy, the result register moves only with done, adder lanes write only during a run, and the live count halves at each round end and stands at 1 when the run closes. Whether the total is arithmetically right, which depends on the odd fold keeping both contributions to entry 0 and on wraparound, can only be shown by the bench's data patterns. The same holds for the exact latency and for the absence of effect of loads and start pulses during a run.

// File: rtl/halving_sum_pkg.sv
// Package: shared types and width helpers for the halving sum reducer.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package halving_sum_pkg;

    // Round sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FOLD   = 2'd1,
        ST_PAIR   = 2'd2,
        ST_FINISH = 2'd3
    } red_state_e;

    // Index width for an entry file of n entries, never below one bit.
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/hs_lane_adder.sv
// Module: one adder lane. Adds two entry operands, modulo 2^W, and
// forwards the lane enable as the write strobe for the entry file.
// Assumes: operands are already selected by the caller.
module hs_lane_adder #(
    parameter int W = 32
) (
    input  logic         en_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         we_o,
    output logic [W-1:0] sum_o
);

    // Wrapping add; carry out is dropped on purpose.
    always_comb begin
        sum_o = a_i + b_i;
        we_o  = en_i;
    end

endmodule

// File: rtl/hs_entry_file.sv
// Module: entry file holding the N partial sums. One load port for the
// host, LANES write ports for the adder lanes, two read ports per lane
// and a fixed read of entry 0.
// Assumes: the caller never enables two writes to the same entry in one
// cycle; out-of-range reads return zero, out-of-range writes are dropped.
module hs_entry_file #(
    parameter int N      = 100,
    parameter int W      = 32,
    parameter int LANES  = 4,
    parameter int IDX_W  = 7,
    parameter int SPAN_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_en_i,
    input  logic [IDX_W-1:0]              ld_idx_i,
    input  logic [W-1:0]                  ld_data_i,
    input  logic [LANES-1:0]              wr_en_i,
    input  logic [LANES-1:0][SPAN_W-1:0]  wr_idx_i,
    input  logic [LANES-1:0][W-1:0]       wr_data_i,
    input  logic [LANES-1:0][SPAN_W-1:0]  rd_a_idx_i,
    input  logic [LANES-1:0][SPAN_W-1:0]  rd_b_idx_i,
    output logic [LANES-1:0][W-1:0]       rd_a_o,
    output logic [LANES-1:0][W-1:0]       rd_b_o,
    output logic [W-1:0]                  head_o
);

    logic [W-1:0] mem_q [N];

    for (genvar e = 0; e < N; e++) begin : g_entry
        // Entry register: reset, host load, then lane writes take effect.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[e] <= '0;
            end else begin
                if (ld_en_i && int'(ld_idx_i) == e) begin
                    mem_q[e] <= ld_data_i;
                end
                for (int k = 0; k < LANES; k++) begin
                    if (wr_en_i[k] && int'(wr_idx_i[k]) == e) begin
                        mem_q[e] <= wr_data_i[k];
                    end
                end
            end
        end
    end

    // Operand reads for every lane, guarded against indices past the file.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            rd_a_o[k] = (int'(rd_a_idx_i[k]) < N) ? mem_q[rd_a_idx_i[k]] : '0;
            rd_b_o[k] = (int'(rd_b_idx_i[k]) < N) ? mem_q[rd_b_idx_i[k]] : '0;
        end
    end

    // Entry 0 feeds the result register.
    assign head_o = mem_q[0];

endmodule

// File: rtl/hs_round_ctrl.sv
// Module: round sequencer. Tracks the live count, the half point of the
// current round and the first lane position of the current pair step.
// A round is one fold cycle followed by ceil(half/LANES) pair cycles.
// Assumes: start is a level sampled each clock; it is ignored unless idle.
module hs_round_ctrl
    import halving_sum_pkg::*;
#(
    parameter int N      = 100,
    parameter int LANES  = 4,
    parameter int SPAN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fold_o,
    output logic              pair_o,
    output logic              finish_o,
    output logic [SPAN_W-1:0] count_o,
    output logic [SPAN_W-1:0] half_o,
    output logic [SPAN_W-1:0] base_o
);

    localparam logic [SPAN_W-1:0] N_S    = SPAN_W'(N);
    localparam logic [SPAN_W-1:0] STEP_S = SPAN_W'(LANES);
    localparam logic [SPAN_W-1:0] ONE_S  = SPAN_W'(1);

    red_state_e        state_q;
    logic [SPAN_W-1:0] count_q;
    logic [SPAN_W-1:0] half_q;
    logic [SPAN_W-1:0] base_q;
    logic [SPAN_W-1:0] base_next;
    logic              last_step;
    logic              done_q;

    // Next pair-step position and end-of-round detection.
    always_comb begin
        base_next = base_q + STEP_S;
        last_step = (base_next >= half_q);
    end

    // Sequencer: accepts start when idle, steps fold and pair phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count_q <= '0;
            half_q  <= '0;
            base_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        count_q <= N_S;
                        base_q  <= '0;
                        state_q <= (N == 1) ? ST_FINISH : ST_FOLD;
                    end
                end
                ST_FOLD: begin
                    half_q  <= count_q >> 1;
                    base_q  <= '0;
                    state_q <= ST_PAIR;
                end
                ST_PAIR: begin
                    base_q <= base_next;
                    if (last_step) begin
                        count_q <= half_q;
                        state_q <= (half_q == ONE_S) ? ST_FINISH : ST_FOLD;
                    end
                end
                ST_FINISH: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decoded phase outputs.
    always_comb begin
        busy_o   = (state_q != ST_IDLE);
        fold_o   = (state_q == ST_FOLD);
        pair_o   = (state_q == ST_PAIR);
        finish_o = (state_q == ST_FINISH);
        done_o   = done_q;
        count_o  = count_q;
        half_o   = half_q;
        base_o   = base_q;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R6

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> state_q == ST_IDLE); // R6

    AST_COUNT_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FOLD) |=> ##0 (state_q == ST_PAIR && half_q == ($past(count_q) >> 1))); // R11

    AST_FINISH_AT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |-> count_q == ONE_S); // R11

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (state_q == ST_FOLD || state_q == ST_PAIR)) |=> state_q != ST_IDLE); // R3

endmodule

// File: rtl/halving_sum_reducer.sv
// Module: top of the halving sum reducer. Wires the entry file, the round
// sequencer and LANES adder lanes; lane 0 also performs the odd fold.
// Holds the result register.
// Assumes: the host loads entries while busy is low, then pulses start.
module halving_sum_reducer #(
    parameter  int N_ENTRIES = 100,
    parameter  int DATA_W    = 32,
    parameter  int LANES     = 4,
    localparam int IDX_W     = halving_sum_pkg::idx_bits(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [DATA_W-1:0] load_data,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);

    localparam int SPAN_W = $clog2(N_ENTRIES + LANES + 1);

    logic                           ld_ok;
    logic                           fold_st;
    logic                           pair_st;
    logic                           finish_st;
    logic [SPAN_W-1:0]              count;
    logic [SPAN_W-1:0]              half;
    logic [SPAN_W-1:0]              base;
    logic [LANES-1:0]               lane_en;
    logic [LANES-1:0]               lane_we;
    logic [LANES-1:0][SPAN_W-1:0]   a_idx;
    logic [LANES-1:0][SPAN_W-1:0]   b_idx;
    logic [LANES-1:0][DATA_W-1:0]   a_val;
    logic [LANES-1:0][DATA_W-1:0]   b_val;
    logic [LANES-1:0][DATA_W-1:0]   lane_sum;
    logic [DATA_W-1:0]              head;

    // Host loads are accepted only when idle and in range.
    always_comb begin
        ld_ok = load_en && !busy && (int'(load_idx) < N_ENTRIES);
    end

    hs_round_ctrl #(
        .N      (N_ENTRIES),
        .LANES  (LANES),
        .SPAN_W (SPAN_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .busy_o   (busy),
        .done_o   (done),
        .fold_o   (fold_st),
        .pair_o   (pair_st),
        .finish_o (finish_st),
        .count_o  (count),
        .half_o   (half),
        .base_o   (base)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [SPAN_W-1:0] pos;
        assign pos = base + SPAN_W'(k);

        if (k == 0) begin : g_fold_lane
            // Lane 0: odd fold of entry count-1 into entry 0, else pair add.
            always_comb begin
                if (fold_st) begin
                    lane_en[k] = count[0];
                    a_idx[k]   = '0;
                    b_idx[k]   = count - SPAN_W'(1);
                end else begin
                    lane_en[k] = pair_st && (pos < half);
                    a_idx[k]   = pos;
                    b_idx[k]   = pos + half;
                end
            end
        end else begin : g_pair_lane
            // Other lanes: pair add of entry pos+half into entry pos.
            always_comb begin
                lane_en[k] = pair_st && (pos < half);
                a_idx[k]   = pos;
                b_idx[k]   = pos + half;
            end
        end

        hs_lane_adder #(
            .W (DATA_W)
        ) u_add (
            .en_i  (lane_en[k]),
            .a_i   (a_val[k]),
            .b_i   (b_val[k]),
            .we_o  (lane_we[k]),
            .sum_o (lane_sum[k])
        );
    end

    hs_entry_file #(
        .N      (N_ENTRIES),
        .W      (DATA_W),
        .LANES  (LANES),
        .IDX_W  (IDX_W),
        .SPAN_W (SPAN_W)
    ) u_file (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en_i    (ld_ok),
        .ld_idx_i   (load_idx),
        .ld_data_i  (load_data),
        .wr_en_i    (lane_we),
        .wr_idx_i   (a_idx),
        .wr_data_i  (lane_sum),
        .rd_a_idx_i (a_idx),
        .rd_b_idx_i (b_idx),
        .rd_a_o     (a_val),
        .rd_b_o     (b_val),
        .head_o     (head)
    );

    // Result register: captures entry 0 as the run closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (finish_st) begin
            result <= head;
        end
    end

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result)); // R7

    AST_LANE_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_we != '0) |-> busy); // R2

    AST_LOAD_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ok |-> (lane_we == '0)); // R2

endmodule

// File: tb/test_halving_sum_reducer.sv
// Bench: table of data patterns with expected totals, walked by one loop,
// then directed tests for reset, busy-time loads and starts, and N = 1.
module test_halving_sum_reducer;

    localparam int NE  = 13;
    localparam int DW  = 8;
    localparam int LN  = 3;
    localparam int IW  = 4;
    localparam int NV  = 6;

    // {seed, step, expected total}; entry i = seed + i*step (mod 256).
    localparam logic [23:0] VEC [NV] = '{
        {8'd0,   8'd1,   8'd78},
        {8'd5,   8'd0,   8'd65},
        {8'd255, 8'd255, 8'd165},
        {8'd1,   8'd2,   8'd169},
        {8'd200, 8'd7,   8'd74},
        {8'd17,  8'd16,  8'd189}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_en = 1'b0;
    logic [IW-1:0] load_idx = '0;
    logic [DW-1:0] load_data = '0;
    logic          start = 1'b0;
    logic          busy;
    logic          done;
    logic [DW-1:0] result;

    logic          l1_en = 1'b0;
    logic [0:0]    l1_idx = '0;
    logic [DW-1:0] l1_data = '0;
    logic          s1 = 1'b0;
    logic          b1;
    logic          d1;
    logic [DW-1:0] r1;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    halving_sum_reducer #(.N_ENTRIES(NE), .DATA_W(DW), .LANES(LN)) i_halving_sum_reducer (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
        .load_data(load_data), .start(start), .busy(busy), .done(done), .result(result)
    );

    halving_sum_reducer #(.N_ENTRIES(1), .DATA_W(DW), .LANES(2)) i_halving_sum_reducer_one (
        .clk(clk), .rst_n(rst_n), .load_en(l1_en), .load_idx(l1_idx),
        .load_data(l1_data), .start(s1), .busy(b1), .done(d1), .result(r1)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected latency in edges from the start-sampling edge to done.
    function automatic int exp_lat(input int n, input int l);
        int c = n;
        int t = 2;
        while (c > 1) begin
            t += 1 + ((c / 2) + l - 1) / l;
            c = c / 2;
        end
        return t;
    endfunction

    task automatic load_set(input logic [DW-1:0] seed, input logic [DW-1:0] step);
        for (int i = 0; i < NE; i++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_idx  = IW'(i);
            load_data = seed + DW'(i) * step;
        end
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // Runs one reduction; optional load or start poke in the third cycle.
    task automatic run(input bit poke_ld, input bit poke_st, output int cyc);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        check(busy === 1'b1, "R9 busy after start", int'(busy), 1);
        while (!done && cyc < 500) begin
            if (cyc == 3) begin
                load_en = poke_ld; load_idx = '0; load_data = 8'hAA;
                start = poke_st;
            end
            @(negedge clk);
            load_en = 1'b0; start = 1'b0;
            cyc++;
        end
    endtask

    initial begin
        #(20 * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc;
        logic [DW-1:0] held;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(busy === 1'b0, "R9 busy in reset", int'(busy), 0);
        check(done === 1'b0, "R9 done in reset", int'(done), 0);
        check(result === '0, "R9 result in reset", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 R5 R10 R6: table walk
        for (int v = 0; v < NV; v++) begin
            load_set(VEC[v][23:16], VEC[v][15:8]);
            run(1'b0, 1'b0, cyc);
            check(result === VEC[v][7:0], "R4 R5 total", int'(result), int'(VEC[v][7:0]));
            check(cyc == exp_lat(NE, LN), "R10 latency", cyc, exp_lat(NE, LN));
            check(busy === 1'b0, "R6 busy low with done", int'(busy), 0);
            @(negedge clk);
            check(done === 1'b0, "R6 done one cycle", int'(done), 0);
        end

        // R7: result held across idle loads
        held = result;
        load_set(8'd9, 8'd3);
        check(result === held, "R7 result held", int'(result), int'(held));

        // R1: out-of-range indices 13..15 do not alter entries; sum of 9+3i = 117+234 = 351 -> 95
        for (int i = NE; i < 16; i++) begin
            @(negedge clk);
            load_en = 1'b1; load_idx = IW'(i); load_data = 8'h77;
        end
        @(negedge clk);
        load_en = 1'b0;
        run(1'b0, 1'b0, cyc);
        check(result === 8'd95, "R1 load and range", int'(result), 95);

        // R2: load to entry 0 while busy is ignored
        load_set(8'd0, 8'd1);
        run(1'b1, 1'b0, cyc);
        check(result === 8'd78, "R2 busy load ignored", int'(result), 78);

        // R3: start while busy ignored
        run(1'b0, 1'b1, cyc);
        check(cyc == exp_lat(NE, LN), "R3 latency unchanged", cyc, exp_lat(NE, LN));
        @(negedge clk);
        check(busy === 1'b0, "R3 no restart", int'(busy), 0);

        // R8: single-entry instance
        @(negedge clk);
        l1_en = 1'b1; l1_idx = 1'b0; l1_data = 8'h5C;
        @(negedge clk);
        l1_en = 1'b0; s1 = 1'b1;
        @(negedge clk);
        s1 = 1'b0;
        check(d1 === 1'b0, "R8 done not yet", int'(d1), 0);
        @(negedge clk);
        check(d1 === 1'b1, "R8 done on second edge", int'(d1), 1);
        check(r1 === 8'h5C, "R8 result is entry 0", int'(r1), 'h5C);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule